// File: doc/BRIEF.md
# Flash Completion Poller (DQ7 Status Polling)

This block runs on the host side of a parallel flash device. Once the command cycles of a program or erase have been written, the host starts the poller with a single request. The request carries the operation kind, an address inside the sector that is being worked on, and the byte that was written. The poller then reads that address over and over through a simple synchronous read port. It watches bit 7 of each returned byte until that bit shows the embedded operation has finished.

The rule for spotting completion depends on the operation. A program is finished when bit 7 matches bit 7 of the written byte. An erase is finished when bit 7 reads one. When the device first signals completion, its lower seven bits can still be out of date. For that reason the poller always makes one more confirming read and takes only that byte as valid. For a program, it compares the confirming byte in full against the written byte. If too many status reads go by without completion, the poller stops and reports a timeout.

The caller must start the request only after the last command write cycle. It must also pick a poll address that lies inside the target sector and is not write-protected. The poller cannot see either condition, so both are the caller's responsibility.

Top module: `flash_poll_engine`

## Requirements
- R1: While reset is held and in the cycle after it is released, busy, rd_en, done, timeout and data_err are all 0.
- R2: When req_valid is high and busy is low, busy goes high in the next cycle and rd_en pulses with rd_addr equal to req_addr. rd_addr keeps that value for every read of the operation.
- R3: For a program (req_op = 0), a returned byte whose bit 7 differs from bit 7 of req_data counts as busy. It leads to another status read.
- R4: For a program, a returned byte whose bit 7 equals bit 7 of req_data counts as completion. No result is reported on that read; a confirming read is issued instead.
- R5: For an erase (req_op = 1), a returned bit 7 of 0 counts as busy and leads to another status read. A returned bit 7 of 1 counts as completion and leads to a confirming read.
- R6: For a program, if the confirming byte equals req_data on all 8 bits, done pulses for one cycle.
- R7: For a program, if the confirming byte differs from req_data on any bit, data_err pulses for one cycle and done stays low.
- R8: For an erase, the confirming byte is not compared, and done pulses for one cycle whatever its value.
- R9: If MAX_POLLS status reads in a row all return busy, timeout pulses for one cycle and no further read is issued. If completion shows on read number MAX_POLLS, the operation still goes on to a confirming read. The confirming read is not counted.
- R10: busy stays high from the cycle after acceptance until the cycle in which the single result pulse (done, timeout or data_err) appears. In that cycle busy is low. A req_valid seen while busy is high is ignored.
- R11: rd_en is high for exactly one cycle per read. A new read is issued only in the cycle after rd_valid returns the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Start request; accepted while busy is low |
| req_op | input | 1 | 0 = program, 1 = erase |
| req_addr | input | AW | Poll address inside the target sector |
| req_data | input | 8 | Byte that was programmed |
| rd_en | output | 1 | One-cycle read strobe |
| rd_addr | output | AW | Read address |
| rd_data | input | 8 | Byte returned by the device |
| rd_valid | input | 1 | rd_data is valid this cycle |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse: completed and confirmed |
| timeout | output | 1 | One-cycle pulse: poll limit reached |
| data_err | output | 1 | One-cycle pulse: programmed byte did not verify |

## Verification
The bench builds the block with AW = 12 and MAX_POLLS = 6, so the poll limit is only a few reads away. This makes both sides of the limit reachable in a short run:
- completion on the sixth read, which still goes on to a confirm and finishes with done;
- six busy reads in a row, which ends in a timeout.

The device model's read latency is varied between 1 and 3 cycles. The bench also covers program data with bit 7 both set and clear, and uses low-bit garbage on the first completion read so that any result taken from it would not match the written byte. It also covers a corrupted confirming byte and a request raised while the poller is busy.

// File: rtl/poll_pkg.sv
package poll_pkg;
  typedef enum logic {
    OP_PROGRAM = 1'b0,
    OP_ERASE   = 1'b1
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_POLL    = 2'd1,
    ST_CONFIRM = 2'd2
  } st_e;
endpackage

// File: rtl/poll_dq7_eval.sv
// Decides whether a status byte shows completion, and whether a confirming
// byte matches the expected value in full.
module poll_dq7_eval
  import poll_pkg::*;
(
  input  op_e        op,
  input  logic [7:0] expect_byte,
  input  logic [7:0] rd_byte,
  output logic       finished,
  output logic       full_match
);
  always_comb begin
    if (op == OP_ERASE)
      finished = rd_byte[7];
    else
      finished = (rd_byte[7] == expect_byte[7]);
    full_match = (rd_byte == expect_byte);
  end
endmodule

// File: rtl/poll_counter.sv
// Counts busy status reads; last is high when the next busy read uses up the limit.
module poll_counter #(
  parameter int unsigned LIMIT = 4096
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic inc,
  output logic last
);
  localparam int unsigned CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr)
      cnt <= '0;
    else if (inc && !last)
      cnt <= cnt + 1'b1;
  end

  assign last = (cnt == CW'(LIMIT - 1));
endmodule

// File: rtl/flash_poll_engine.sv
module flash_poll_engine
  import poll_pkg::*;
#(
  parameter int unsigned AW        = 20,
  parameter int unsigned MAX_POLLS = 4096
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic          req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [7:0]    req_data,
  output logic          rd_en,
  output logic [AW-1:0] rd_addr,
  input  logic [7:0]    rd_data,
  input  logic          rd_valid,
  output logic          busy,
  output logic          done,
  output logic          timeout,
  output logic          data_err
);
  st_e        st;
  op_e        op_q;
  logic [7:0] exp_q;
  logic       dq7_ok;
  logic       byte_ok;
  logic       cnt_clr;
  logic       cnt_inc;
  logic       cnt_last;

  poll_dq7_eval u_eval (
    .op          (op_q),
    .expect_byte (exp_q),
    .rd_byte     (rd_data),
    .finished    (dq7_ok),
    .full_match  (byte_ok)
  );

  assign cnt_clr = (st == ST_IDLE);
  assign cnt_inc = (st == ST_POLL) && rd_valid && !dq7_ok;

  poll_counter #(.LIMIT(MAX_POLLS)) u_cnt (
    .clk  (clk),
    .rst  (rst),
    .clr  (cnt_clr),
    .inc  (cnt_inc),
    .last (cnt_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      op_q     <= OP_PROGRAM;
      exp_q    <= '0;
      rd_en    <= 1'b0;
      rd_addr  <= '0;
      busy     <= 1'b0;
      done     <= 1'b0;
      timeout  <= 1'b0;
      data_err <= 1'b0;
    end else begin
      rd_en    <= 1'b0;
      done     <= 1'b0;
      timeout  <= 1'b0;
      data_err <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (req_valid) begin
            st      <= ST_POLL;
            busy    <= 1'b1;
            rd_en   <= 1'b1;
            rd_addr <= req_addr;
            op_q    <= op_e'(req_op);
            exp_q   <= req_data;
          end
        end
        ST_POLL: begin
          if (rd_valid) begin
            if (dq7_ok) begin
              st    <= ST_CONFIRM;
              rd_en <= 1'b1;
            end else if (cnt_last) begin
              st      <= ST_IDLE;
              busy    <= 1'b0;
              timeout <= 1'b1;
            end else begin
              rd_en <= 1'b1;
            end
          end
        end
        ST_CONFIRM: begin
          if (rd_valid) begin
            st   <= ST_IDLE;
            busy <= 1'b0;
            if (op_q == OP_PROGRAM && !byte_ok)
              data_err <= 1'b1;
            else
              done <= 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/flash_poll_engine_chk.sv
module flash_poll_engine_chk #(
  parameter int unsigned AW = 20
) (
  input logic          clk,
  input logic          rst,
  input logic          req_valid,
  input logic [AW-1:0] req_addr,
  input logic          rd_en,
  input logic [AW-1:0] rd_addr,
  input logic          busy,
  input logic          done,
  input logic          timeout,
  input logic          data_err
);
  // R10
  result_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({done, timeout, data_err}));

  // R10
  result_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (done || timeout || data_err) |-> !busy);

  // R10
  busy_drop_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (done || timeout || data_err));

  // R2
  accept_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !busy) |=> (busy && rd_en && rd_addr == $past(req_addr)));

  // R2
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(rd_addr));

  // R11
  strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> !rd_en);

  // R9
  timeout_noread_chk: assert property (@(posedge clk) disable iff (rst)
    timeout |-> !rd_en);
endmodule

bind flash_poll_engine flash_poll_engine_chk #(.AW(AW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_addr  (req_addr),
  .rd_en     (rd_en),
  .rd_addr   (rd_addr),
  .busy      (busy),
  .done      (done),
  .timeout   (timeout),
  .data_err  (data_err)
);

// File: tb/flash_poll_engine_tb_top.sv
`timescale 1ns/1ps
module flash_poll_engine_tb_top;
  localparam int AW   = 12;
  localparam int MAXP = 6;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic          req_op = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [7:0]    req_data = '0;
  logic          rd_en;
  logic [AW-1:0] rd_addr;
  logic [7:0]    rd_data = '0;
  logic          rd_valid = 1'b0;
  logic          busy, done, timeout, data_err;

  always #2.5 clk = ~clk;

  flash_poll_engine #(.AW(AW), .MAX_POLLS(MAXP)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_data(req_data), .rd_en(rd_en),
    .rd_addr(rd_addr), .rd_data(rd_data), .rd_valid(rd_valid),
    .busy(busy), .done(done), .timeout(timeout), .data_err(data_err)
  );

  int vectors = 0;
  int fails   = 0;
  bit finished = 1'b0;

  // device model state, set by the test task
  int         dev_busy_left;
  bit         dev_first_seen;
  bit         dev_erase;
  logic [7:0] dev_data;
  logic [7:0] dev_corrupt;
  int         dev_lat = 1;
  int         pend = 0;

  function automatic logic [7:0] dev_answer();
    logic [7:0] b;
    if (dev_busy_left > 0) begin
      dev_busy_left--;
      b = dev_erase ? {1'b0, ~dev_data[6:0]} : {~dev_data[7], ~dev_data[6:0]};
    end else if (!dev_first_seen) begin
      dev_first_seen = 1'b1;
      b = dev_erase ? {1'b1, 7'h2A} : {dev_data[7], ~dev_data[6:0]};
    end else begin
      b = dev_erase ? 8'hFF : (dev_data ^ dev_corrupt);
    end
    return b;
  endfunction

  always @(posedge clk) begin
    rd_valid <= 1'b0;
    if (rst) begin
      pend = 0;
    end else begin
      if (rd_en) pend = dev_lat;
      if (pend > 0) begin
        pend--;
        if (pend == 0) begin
          rd_valid <= 1'b1;
          rd_data  <= dev_answer();
        end
      end
    end
  end

  // behavioural reference
  bit         m_busy, m_confirm, m_erase;
  int         m_cnt;
  logic [7:0] m_data;
  logic [AW-1:0] e_addr = '0;
  bit e_rd_en, e_done, e_to, e_err, e_busy;

  always @(posedge clk) begin
    e_rd_en <= 1'b0; e_done <= 1'b0; e_to <= 1'b0; e_err <= 1'b0;
    if (rst) begin
      m_busy = 0; m_confirm = 0; m_cnt = 0;
      e_busy <= 1'b0; e_addr <= '0;
    end else if (!m_busy) begin
      if (req_valid) begin
        m_busy = 1; m_confirm = 0; m_cnt = 0;
        m_erase = req_op; m_data = req_data;
        e_busy <= 1'b1; e_rd_en <= 1'b1; e_addr <= req_addr;
      end
    end else if (rd_valid) begin
      if (m_confirm) begin
        m_busy = 0;
        e_busy <= 1'b0;
        if (!m_erase && rd_data != m_data) e_err <= 1'b1;
        else e_done <= 1'b1;
      end else if (m_erase ? rd_data[7] : (rd_data[7] == m_data[7])) begin
        m_confirm = 1;
        e_rd_en <= 1'b1;
      end else begin
        m_cnt++;
        if (m_cnt >= MAXP) begin
          m_busy = 0;
          e_busy <= 1'b0; e_to <= 1'b1;
        end else begin
          e_rd_en <= 1'b1;
        end
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // compare on every cycle once the model is meaningful
  bit cmp_on = 1'b0;
  int reads  = 0;
  always @(negedge clk) begin
    if (rd_en) reads++;
    if (cmp_on) begin
      check(busy == e_busy, "R10", "busy", busy, e_busy);
      check(rd_en == e_rd_en, "R11", "rd_en", rd_en, e_rd_en);
      check(done == e_done, "R6", "done", done, e_done);
      check(timeout == e_to, "R9", "timeout", timeout, e_to);
      check(data_err == e_err, "R7", "data_err", data_err, e_err);
      if (e_rd_en) check(rd_addr == e_addr, "R2", "rd_addr", rd_addr, e_addr);
    end
  end

  // kind: 0 done, 1 timeout, 2 data_err
  task automatic run_op(input bit erase, input logic [AW-1:0] addr,
                        input logic [7:0] data, input int busy_reads,
                        input logic [7:0] corrupt, input int lat,
                        input bit poke, input int exp_kind,
                        input int exp_reads, input string req);
    int guard = 0;
    dev_busy_left = busy_reads; dev_first_seen = 1'b0; dev_erase = erase;
    dev_data = data; dev_corrupt = corrupt; dev_lat = lat;
    reads = 0;
    req_valid = 1'b1; req_op = erase; req_addr = addr; req_data = data;
    @(negedge clk);
    req_valid = 1'b0;
    if (poke) begin
      @(negedge clk);
      req_valid = 1'b1; req_addr = ~addr; req_op = ~erase; req_data = ~data;
      @(negedge clk);
      req_valid = 1'b0;
      check(busy == 1'b1, "R10", "busy while poked", busy, 1);
    end
    while (!(done || timeout || data_err) && guard < 500) begin
      @(negedge clk);
      guard++;
    end
    check(done == (exp_kind == 0), req, "done result", done, exp_kind == 0);
    check(timeout == (exp_kind == 1), req, "timeout result", timeout, exp_kind == 1);
    check(data_err == (exp_kind == 2), req, "data_err result", data_err, exp_kind == 2);
    check(reads == exp_reads, req, "read count", reads, exp_reads);
    check(rd_addr == addr, "R2", "held address", rd_addr, addr);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs clear under reset
    check({busy, rd_en, done, timeout, data_err} == 5'b0, "R1", "reset outputs",
          {busy, rd_en, done, timeout, data_err}, 0);
    rst = 1'b0;
    @(negedge clk);
    check({busy, rd_en, done, timeout, data_err} == 5'b0, "R1", "after reset",
          {busy, rd_en, done, timeout, data_err}, 0);
    cmp_on = 1'b1;
    // R3 R4 R6: program, bit7 set, three busy reads
    run_op(1'b0, 12'h123, 8'hA5, 3, 8'h00, 1, 1'b0, 0, 5, "R3");
    // R4 R6: program, bit7 clear, immediate completion, latency 2
    run_op(1'b0, 12'h040, 8'h3C, 0, 8'h00, 2, 1'b0, 0, 2, "R4");
    // R5 R8: erase with two busy reads, confirm byte not compared
    run_op(1'b1, 12'h800, 8'h12, 2, 8'h00, 1, 1'b0, 0, 4, "R5");
    // R7: corrupted confirm byte
    run_op(1'b0, 12'h0F0, 8'h81, 1, 8'h01, 1, 1'b0, 2, 3, "R7");
    // R9: limit reached with all reads busy
    run_op(1'b1, 12'h7FF, 8'h00, MAXP, 8'h00, 1, 1'b0, 1, MAXP, "R9");
    // R9: completion on the last allowed read still confirms
    run_op(1'b0, 12'h555, 8'h6E, MAXP - 1, 8'h00, 2, 1'b0, 0, MAXP + 1, "R9");
    // R10: request raised while busy is ignored
    run_op(1'b0, 12'hABC, 8'hC3, 2, 8'h00, 3, 1'b1, 0, 4, "R10");
    // R8: erase, latency 3, immediate completion
    run_op(1'b1, 12'h00F, 8'h77, 0, 8'h00, 3, 1'b0, 0, 2, "R8");
    // R11: program timeout, latency 3
    run_op(1'b0, 12'h321, 8'h10, MAXP + 2, 8'h00, 3, 1'b0, 1, MAXP, "R11");
    repeat (4) @(negedge clk);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      vectors++;
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule